// File: doc/BRIEF.md
# Quad-Lane Serial Flash Command Sequencer

This block produces one complete serial-flash command frame on a four-lane SPI bus each time it is started. The frame is built from up to five phases in a fixed order: an 8-bit instruction, an address of 24 or 32 bits, a short option code, a run of dummy clocks and a data phase of a programmed number of bytes. Each phase can be switched off by itself. A 3-bit width mode picks how many lanes (1, 2 or 4) the instruction, the address/option pair and the data use. Double data rate, when enabled, moves two lane groups per clock in the address, option and data phases. The instruction phase joins in only when a second enable is also set.

The block works in system-clock units: each cycle in which `sck_en` is high is one serial clock. A pad stage outside the block puts `io_out_p` on the lanes for the rising half of that clock and `io_out_n` for the falling half. It returns what it sampled on the two halves through `io_in_p` and `io_in_n`. All configuration is captured on the `start` cycle. A setting the block cannot carry out is refused with an `err` pulse and no frame. `start` has no effect while a frame is running.

The state machine has eight states:
- IDLE: chip select is high.
- SETUP: one cycle with chip select low and no clock.
- The phase states INST, ADDR, OPT, DUMMY and DATA.
- HOLD: one cycle after the last phase.

The transitions are:
- IDLE goes to SETUP on a start with a valid setting.
- SETUP goes to the first enabled phase, or to HOLD if none is enabled.
- Each phase goes, on its last cycle, to the next enabled phase in order, or to HOLD.
- DATA loops on itself between bytes.
- HOLD goes to IDLE.

Top module: `qcmd_seq`

## Requirements
- R1: `cs_n` goes low in the cycle after an accepted `start`. That first cycle (SETUP) has `sck_en` low. After the last phase there is one cycle with `cs_n` low, `sck_en` low and `done` high; in the cycle after it `cs_n` is high and `done` is low. `done` is high for exactly one cycle per frame.
- R2: Phases run in the order instruction, address, option, dummy, data, and a disabled phase takes no cycles. The dummy phase is absent when its count is 0. The data phase is absent when the byte count is 0.
- R3: The width mode sets lanes (instruction / address+option / data) as follows: 0 = 1/1/1, 1 = 1/1/2, 2 = 1/1/4, 3 = 1/2/2, 4 = 1/4/4, 5 = 2/2/2, 6 = 4/4/4. With L lanes, lanes 0..L-1 carry the bits, most significant bit first, and the highest used lane carries the most significant bit of each group. Unused lanes are 0, and `io_oe` is 1 exactly on the lanes being driven.
- R4: The instruction phase sends `instr_code` (8 bits). It uses double data rate only when both `ddr_en` and `ddr_cmd_en` are 1. `ddr_cmd_en` has no effect while `ddr_en` is 0.
- R5: The address phase sends the low 24 bits of `address` when `addr_32b` is 0, and all 32 bits when it is 1.
- R6: The option phase sends the low N bits of `opt_code`, where `opt_len` 0/1/2/3 gives N = 1/2/4/8.
- R7: With `ddr_en` set, each address, option and data cycle carries two lane groups and `ddr_act` is high: the earlier group on `io_out_p`, the later one on `io_out_n`. In a single-rate cycle `ddr_act` is low and `io_out_n` equals `io_out_p`.
- R8: The dummy phase lasts exactly `dummy_cycles` cycles (0 to 31) with `sck_en` high, `io_oe` all 0 and `ddr_act` low.
- R9: In a write frame (`rd_dir` = 0), `tx_pop` is high once per data byte, in the cycle just before that byte's first cycle. `tx_data` is taken in that cycle and sent in the following data cycles.
- R10: In a read frame, `io_oe` is 0 in the data phase. Lanes are sampled from `io_in_p` and, in double data rate only, from `io_in_n`, and are assembled most significant bit first. `rx_valid` pulses in the cycle after each byte's last cycle, with the byte on `rx_data`. `io_in_n` is ignored at single rate.
- R11: A `start` with width mode 7, or with the option enabled and N smaller than the address/option lane count times the rate (2 in double data rate, else 1), is refused. `err` is high for one cycle after it, `cs_n` stays high and no `done` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a frame with the configuration present this cycle |
| inst_en | input | 1 | Send the instruction phase |
| addr_en | input | 1 | Send the address phase |
| opt_en | input | 1 | Send the option phase |
| data_en | input | 1 | Run the data phase |
| width_mode | input | 3 | Lane-count mode per phase |
| addr_32b | input | 1 | Address length: 0 = 24 bits, 1 = 32 bits |
| opt_len | input | 2 | Option length code |
| dummy_cycles | input | DUMMY_W | Number of dummy clocks |
| ddr_en | input | 1 | Double data rate for address, option and data |
| ddr_cmd_en | input | 1 | Also use double data rate for the instruction |
| rd_dir | input | 1 | Data direction: 1 = read, 0 = write |
| byte_count | input | BCNT_W | Data bytes in the frame |
| instr_code | input | 8 | Instruction value |
| address | input | 32 | Address value |
| opt_code | input | 8 | Option code value |
| tx_data | input | 8 | Write byte, taken while `tx_pop` is high |
| tx_pop | output | 1 | Write byte consumed this cycle |
| rx_data | output | 8 | Last byte read |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| cs_n | output | 1 | Chip select, active low |
| sck_en | output | 1 | Serial clock runs this cycle |
| ddr_act | output | 1 | This cycle carries two lane groups |
| io_out_p | output | 4 | Lane values for the rising half |
| io_out_n | output | 4 | Lane values for the falling half |
| io_oe | output | 4 | Per-lane output enable |
| io_in_p | input | 4 | Lanes sampled on the rising half |
| io_in_n | input | 4 | Lanes sampled on the falling half |
| done | output | 1 | Frame-end pulse |
| err | output | 1 | Refused-start pulse |

## Verification
The checker watches rules that hold on every cycle:
- the single-cycle `done` and its return of `cs_n` to high;
- a quiet bus while chip select is high;
- `io_oe` only ever forming a contiguous low-lane mask;
- equal halves in single-rate cycles;
- `err` never coinciding with an active frame;
- `tx_pop` and `rx_valid` only appearing inside a frame with the lanes in the right direction.

Only the bench's sweep can show the rest: the exact bit placed on each lane in each cycle, phase ordering and skipping, the phase lengths set by address length, option length, dummy count and rate, and the bytes assembled from the input lanes. It does this across every width mode, both rates, both instruction-rate settings, both address lengths and all option lengths.

// File: rtl/qcmd_pkg.sv
package qcmd_pkg;

    // Phase states occupy consecutive codes from ST_INST so that the
    // phase index maps to the state by a fixed offset.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_INST  = 3'd2,
        ST_ADDR  = 3'd3,
        ST_OPT   = 3'd4,
        ST_DUMMY = 3'd5,
        ST_DATA  = 3'd6,
        ST_HOLD  = 3'd7
    } qcmd_state_e;

    typedef struct packed {
        logic       inst_en;
        logic       addr_en;
        logic       opt_en;
        logic       data_en;
        logic [2:0] mode;
        logic       addr32;
        logic [1:0] opt_len;
        logic       ddr;
        logic       ddr_cmd;
        logic       rd;
    } qcmd_cfg_t;

    function automatic logic [3:0] lane_mask(input logic [1:0] lg);
        case (lg)
            2'd0:    return 4'b0001;
            2'd1:    return 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

endpackage

// File: rtl/qcmd_lane_map.sv
module qcmd_lane_map (
    input  logic [2:0] mode,
    output logic [1:0] lg_inst,
    output logic [1:0] lg_ao,
    output logic [1:0] lg_data,
    output logic       mode_ok
);
    // Lane counts are carried as log2: 0 = 1 lane, 1 = 2 lanes, 2 = 4 lanes.
    always_comb begin
        mode_ok = 1'b1;
        unique case (mode)
            3'd0: {lg_inst, lg_ao, lg_data} = {2'd0, 2'd0, 2'd0};
            3'd1: {lg_inst, lg_ao, lg_data} = {2'd0, 2'd0, 2'd1};
            3'd2: {lg_inst, lg_ao, lg_data} = {2'd0, 2'd0, 2'd2};
            3'd3: {lg_inst, lg_ao, lg_data} = {2'd0, 2'd1, 2'd1};
            3'd4: {lg_inst, lg_ao, lg_data} = {2'd0, 2'd2, 2'd2};
            3'd5: {lg_inst, lg_ao, lg_data} = {2'd1, 2'd1, 2'd1};
            3'd6: {lg_inst, lg_ao, lg_data} = {2'd2, 2'd2, 2'd2};
            default: begin
                {lg_inst, lg_ao, lg_data} = '0;
                mode_ok = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/qcmd_rx_assemble.sv
module qcmd_rx_assemble #(
    parameter int BYTE_W = 8
) (
    input  logic [1:0]        lg,
    input  logic              ddr,
    input  logic [BYTE_W-1:0] cur,
    input  logic [3:0]        in_p,
    input  logic [3:0]        in_n,
    output logic [BYTE_W-1:0] nxt
);
    function automatic logic [BYTE_W-1:0] push(input logic [BYTE_W-1:0] v,
                                               input logic [1:0] l,
                                               input logic [3:0] d);
        case (l)
            2'd0:    return {v[BYTE_W-2:0], d[0]};
            2'd1:    return {v[BYTE_W-3:0], d[1:0]};
            default: return {v[BYTE_W-5:0], d[3:0]};
        endcase
    endfunction

    logic [BYTE_W-1:0] after_p;

    always_comb begin
        after_p = push(cur, lg, in_p);
        nxt     = ddr ? push(after_p, lg, in_n) : after_p;
    end
endmodule

// File: rtl/qcmd_seq.sv
module qcmd_seq #(
    parameter int DUMMY_W = 5,
    parameter int BCNT_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               inst_en,
    input  logic               addr_en,
    input  logic               opt_en,
    input  logic               data_en,
    input  logic [2:0]         width_mode,
    input  logic               addr_32b,
    input  logic [1:0]         opt_len,
    input  logic [DUMMY_W-1:0] dummy_cycles,
    input  logic               ddr_en,
    input  logic               ddr_cmd_en,
    input  logic               rd_dir,
    input  logic [BCNT_W-1:0]  byte_count,
    input  logic [7:0]         instr_code,
    input  logic [31:0]        address,
    input  logic [7:0]         opt_code,
    input  logic [7:0]         tx_data,
    output logic               tx_pop,
    output logic [7:0]         rx_data,
    output logic               rx_valid,
    output logic               cs_n,
    output logic               sck_en,
    output logic               ddr_act,
    output logic [3:0]         io_out_p,
    output logic [3:0]         io_out_n,
    output logic [3:0]         io_oe,
    input  logic [3:0]         io_in_p,
    input  logic [3:0]         io_in_n,
    output logic               done,
    output logic               err
);
    import qcmd_pkg::*;

    localparam int CNT_W = (DUMMY_W > 5) ? DUMMY_W : 5;
    localparam int LEN_W = CNT_W + 1;

    qcmd_state_e        state_q, state_d;
    qcmd_cfg_t          cfg_q;
    logic [DUMMY_W-1:0] dummy_q;
    logic [BCNT_W-1:0]  bytes_q;
    logic [7:0]         instr_q, opt_q, rxsh_q, rx_nxt, rxd_q;
    logic [31:0]        addr_q, shreg_q, ld_val;
    logic [CNT_W-1:0]   cnt_q, cnt_ld;
    logic [LEN_W-1:0]   ld_len;
    logic               err_q, rxv_q;

    logic [2:0] map_mode;
    logic [1:0] lg_i, lg_a, lg_d, lg_cur, lg_nx;
    logic       mode_ok, ddr_cur, ddr_nx, start_ok, in_phase, load_ph, drive;
    logic [4:0] phase_en;
    logic [3:0] opt_n;

    function automatic logic is_phase(input qcmd_state_e st);
        return (st >= ST_INST) && (st <= ST_DATA);
    endfunction

    function automatic qcmd_state_e pick(input logic [4:0] en, input int from);
        qcmd_state_e r   = ST_HOLD;
        logic        hit = 1'b0;
        for (int i = 0; i < 5; i++) begin
            if (!hit && i >= from && en[i]) begin
                r   = qcmd_state_e'(3'(i + 2));
                hit = 1'b1;
            end
        end
        return r;
    endfunction

    function automatic logic [1:0] lg_of(input qcmd_state_e st, input logic [1:0] li,
                                         input logic [1:0] la, input logic [1:0] ld);
        case (st)
            ST_INST:        return li;
            ST_ADDR,ST_OPT: return la;
            ST_DATA:        return ld;
            default:        return 2'd0;
        endcase
    endfunction

    function automatic logic rate_of(input qcmd_state_e st, input logic d, input logic dc);
        case (st)
            ST_INST:                return d & dc;
            ST_ADDR,ST_OPT,ST_DATA: return d;
            default:                return 1'b0;
        endcase
    endfunction

    // While idle the map judges the incoming mode; afterwards the captured one.
    assign map_mode = (state_q == ST_IDLE) ? width_mode : cfg_q.mode;

    qcmd_lane_map u_map (
        .mode    (map_mode),
        .lg_inst (lg_i),
        .lg_ao   (lg_a),
        .lg_data (lg_d),
        .mode_ok (mode_ok)
    );

    assign start_ok = mode_ok &&
                      !(opt_en && ({1'b0, opt_len} < ({1'b0, lg_a} + {2'b0, ddr_en})));

    assign phase_en = {cfg_q.data_en && (bytes_q != '0), dummy_q != '0,
                       cfg_q.opt_en, cfg_q.addr_en, cfg_q.inst_en};

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start && start_ok) state_d = ST_SETUP;
            ST_SETUP: state_d = pick(phase_en, 0);
            ST_INST, ST_ADDR, ST_OPT, ST_DUMMY, ST_DATA: begin
                if (cnt_q == '0) begin
                    if (state_q == ST_DATA && bytes_q > BCNT_W'(1)) state_d = ST_DATA;
                    else state_d = pick(phase_en, int'(state_q) - 1);
                end
            end
            ST_HOLD:  state_d = ST_IDLE;
        endcase
    end

    // Phase loading for the state about to be entered
    always_comb begin
        in_phase = is_phase(state_q);
        load_ph  = is_phase(state_d) && ((state_d != state_q) || (cnt_q == '0));
        lg_cur   = lg_of(state_q, lg_i, lg_a, lg_d);
        ddr_cur  = rate_of(state_q, cfg_q.ddr, cfg_q.ddr_cmd);
        lg_nx    = lg_of(state_d, lg_i, lg_a, lg_d);
        ddr_nx   = rate_of(state_d, cfg_q.ddr, cfg_q.ddr_cmd);
        opt_n    = 4'd1 << cfg_q.opt_len;
        ld_val   = '0;
        ld_len   = LEN_W'(8);
        case (state_d)
            ST_INST: ld_val = {instr_q, 24'h0};
            ST_ADDR: begin
                ld_val = cfg_q.addr32 ? addr_q : {addr_q[23:0], 8'h0};
                ld_len = cfg_q.addr32 ? LEN_W'(32) : LEN_W'(24);
            end
            ST_OPT: begin
                ld_val = {opt_q << (4'd8 - opt_n), 24'h0};
                ld_len = LEN_W'(opt_n);
            end
            ST_DUMMY: ld_len = LEN_W'(dummy_q);
            ST_DATA:  ld_val = cfg_q.rd ? 32'h0 : {tx_data, 24'h0};
            default:  ld_len = LEN_W'(8);
        endcase
        cnt_ld = CNT_W'((ld_len >> ({1'b0, lg_nx} + {2'b0, ddr_nx})) - LEN_W'(1));
    end

    qcmd_rx_assemble #(.BYTE_W(8)) u_rx (
        .lg   (lg_d),
        .ddr  (cfg_q.ddr),
        .cur  (rxsh_q),
        .in_p (io_in_p),
        .in_n (io_in_n),
        .nxt  (rx_nxt)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            dummy_q <= '0;
            bytes_q <= '0;
            instr_q <= '0;
            addr_q  <= '0;
            opt_q   <= '0;
            shreg_q <= '0;
            cnt_q   <= '0;
            rxsh_q  <= '0;
            rxd_q   <= '0;
            rxv_q   <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            rxv_q <= 1'b0;
            err_q <= 1'b0;
            if (state_q == ST_IDLE && start) begin
                if (start_ok) begin
                    cfg_q   <= '{inst_en, addr_en, opt_en, data_en, width_mode, addr_32b,
                                 opt_len, ddr_en, ddr_cmd_en, rd_dir};
                    dummy_q <= dummy_cycles;
                    bytes_q <= byte_count;
                    instr_q <= instr_code;
                    addr_q  <= address;
                    opt_q   <= opt_code;
                end else begin
                    err_q <= 1'b1;
                end
            end
            if (load_ph) begin
                shreg_q <= ld_val;
                cnt_q   <= cnt_ld;
            end else if (in_phase && cnt_q != '0) begin
                shreg_q <= shreg_q << (6'd1 << ({1'b0, lg_cur} + {2'b0, ddr_cur}));
                cnt_q   <= cnt_q - CNT_W'(1);
            end
            if (state_q == ST_DATA && cnt_q == '0) bytes_q <= bytes_q - BCNT_W'(1);
            if (state_q == ST_DATA && cfg_q.rd) begin
                rxsh_q <= rx_nxt;
                if (cnt_q == '0) begin
                    rxd_q <= rx_nxt;
                    rxv_q <= 1'b1;
                end
            end
        end
    end

    // Outputs
    always_comb begin
        drive    = in_phase && (state_q != ST_DUMMY) && !(state_q == ST_DATA && cfg_q.rd);
        cs_n     = (state_q == ST_IDLE);
        sck_en   = in_phase;
        done     = (state_q == ST_HOLD);
        ddr_act  = ddr_cur;
        err      = err_q;
        rx_valid = rxv_q;
        rx_data  = rxd_q;
        tx_pop   = load_ph && (state_d == ST_DATA) && !cfg_q.rd;
        io_oe    = drive ? lane_mask(lg_cur) : 4'b0000;
        io_out_p = 4'b0000;
        io_out_n = 4'b0000;
        if (drive) begin
            case (lg_cur)
                2'd0: begin
                    io_out_p = {3'b000, shreg_q[31]};
                    io_out_n = {3'b000, shreg_q[30]};
                end
                2'd1: begin
                    io_out_p = {2'b00, shreg_q[31:30]};
                    io_out_n = {2'b00, shreg_q[29:28]};
                end
                default: begin
                    io_out_p = shreg_q[31:28];
                    io_out_n = shreg_q[27:24];
                end
            endcase
            if (!ddr_cur) io_out_n = io_out_p;
        end
    end
endmodule

// File: rtl/qcmd_seq_chk.sv
module qcmd_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       sck_en,
    input logic       ddr_act,
    input logic [3:0] io_out_p,
    input logic [3:0] io_out_n,
    input logic [3:0] io_oe,
    input logic       done,
    input logic       err,
    input logic       tx_pop,
    input logic       rx_valid
);
    p_done_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_cs_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> cs_n);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (!sck_en && io_oe == 4'b0000 && !done));

    p_oe_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((io_oe & (io_oe + 4'd1)) == 4'b0000));

    p_sdr_halves_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ddr_act |-> (io_out_p == io_out_n));

    p_err_no_frame_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (cs_n && !done));

    p_err_stays_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> cs_n);

    p_pop_in_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> !cs_n);

    p_rx_lanes_in_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (!cs_n && io_oe == 4'b0000));
endmodule

bind qcmd_seq qcmd_seq_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .sck_en   (sck_en),
    .ddr_act  (ddr_act),
    .io_out_p (io_out_p),
    .io_out_n (io_out_n),
    .io_oe    (io_oe),
    .done     (done),
    .err      (err),
    .tx_pop   (tx_pop),
    .rx_valid (rx_valid)
);

// File: tb/qcmd_seq_tb_top.sv
module qcmd_seq_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic       inst_en = 0, addr_en = 0, opt_en = 0, data_en = 0;
    logic [2:0] width_mode = 0;
    logic       addr_32b = 0;
    logic [1:0] opt_len = 0;
    logic [4:0] dummy_cycles = 0;
    logic       ddr_en = 0, ddr_cmd_en = 0, rd_dir = 0;
    logic [7:0] byte_count = 0, instr_code = 0, opt_code = 0, tx_data = 0;
    logic [31:0] address = 0;
    logic       tx_pop, rx_valid, cs_n, sck_en, ddr_act, done, err;
    logic [7:0] rx_data;
    logic [3:0] io_out_p, io_out_n, io_oe;
    logic [3:0] io_in_p = 0, io_in_n = 0;

    int checks = 0, fails = 0, pc = 0;
    bit ended = 0;
    logic [7:0] txb [4];
    logic [7:0] rxb [4];

    qcmd_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .inst_en(inst_en), .addr_en(addr_en),
        .opt_en(opt_en), .data_en(data_en), .width_mode(width_mode), .addr_32b(addr_32b),
        .opt_len(opt_len), .dummy_cycles(dummy_cycles), .ddr_en(ddr_en),
        .ddr_cmd_en(ddr_cmd_en), .rd_dir(rd_dir), .byte_count(byte_count),
        .instr_code(instr_code), .address(address), .opt_code(opt_code),
        .tx_data(tx_data), .tx_pop(tx_pop), .rx_data(rx_data), .rx_valid(rx_valid),
        .cs_n(cs_n), .sck_en(sck_en), .ddr_act(ddr_act), .io_out_p(io_out_p),
        .io_out_n(io_out_n), .io_oe(io_oe), .io_in_p(io_in_p), .io_in_n(io_in_n),
        .done(done), .err(err)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Write-byte source: present the next byte, advance after each pop (R9).
    always @(negedge clk) begin
        tx_data = txb[pc < 4 ? pc : 3];
        if (tx_pop === 1'b1) pc = pc + 1;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int lanes(input int mode, input int ph);
        int t[7][3] = '{'{1,1,1}, '{1,1,2}, '{1,1,4}, '{1,2,2}, '{1,4,4}, '{2,2,2}, '{4,4,4}};
        return t[mode][ph];
    endfunction

    function automatic int lg2(input int l);
        return (l == 4) ? 2 : (l == 2) ? 1 : 0;
    endfunction

    function automatic logic [3:0] grp(input logic [31:0] v, input int bits, input int l, input int g);
        logic [3:0] r = 4'b0000;
        for (int j = 0; j < l; j++) r[j] = v[bits - 1 - (g * l + (l - 1 - j))];
        return r;
    endfunction

    function automatic logic [3:0] mask(input int l);
        return 4'((1 << l) - 1);
    endfunction

    // One phase: check each cycle's lanes and, for reads, feed the input lanes.
    task automatic chk_phase(input string tag, input logic [31:0] v, input int bits,
                             input int l, input int r, input bit drv, input bit rd,
                             input logic [7:0] rbyte, input bit rx_exp, input logic [7:0] rx_prev);
        for (int c = 0; c < bits / (l * r); c++) begin
            logic [3:0] ep, en;
            @(negedge clk);
            ep = drv ? grp(v, bits, l, c * r) : 4'b0000;
            en = drv ? grp(v, bits, l, c * r + r - 1) : 4'b0000;
            check(tag, {14'b0, cs_n, sck_en, ddr_act, io_oe, io_out_p, io_out_n},
                       {14'b0, 1'b0, 1'b1, r == 2, drv ? mask(l) : 4'b0000, ep, en});
            if (c == 0 && rx_exp)
                check("R10 rx byte", {23'b0, rx_valid, rx_data}, {23'b0, 1'b1, rx_prev});
            if (rd) begin
                io_in_p = grp({24'b0, rbyte}, 8, l, c * r);
                io_in_n = (r == 2) ? grp({24'b0, rbyte}, 8, l, c * r + 1) : ~io_in_p;
            end else begin
                io_in_p = 4'b0000;
                io_in_n = 4'b0000;
            end
        end
    endtask

    task automatic run_frame(input int mode, input bit ddr, input bit cmd, input bit a32,
                             input int ol, input bit ie, input bit ae, input bit oe_, input bit de,
                             input int dum, input int nb, input bit rd, input int seed);
        bit bad;
        int li, la, ld, ri, ra, ob;
        logic [7:0] ins, opc;
        logic [31:0] adr;
        ins = 8'(8'hA5 ^ seed);
        opc = 8'(seed * 37 + 11);
        adr = 32'h1357_9BDF * 32'(seed + 1) ^ 32'hC0DE_0F1E;
        for (int b = 0; b < 4; b++) begin
            txb[b] = 8'(seed * 13 + b * 71 + 5);
            rxb[b] = 8'(seed * 29 + b * 53 + 9);
        end
        pc = 0;
        bad = (mode == 7) || (oe_ && ol < lg2(lanes(mode, 1)) + int'(ddr));
        @(negedge clk);
        {inst_en, addr_en, opt_en, data_en} = {ie, ae, oe_, de};
        width_mode = 3'(mode); ddr_en = ddr; ddr_cmd_en = cmd; addr_32b = a32;
        opt_len = 2'(ol); dummy_cycles = 5'(dum); byte_count = 8'(nb); rd_dir = rd;
        instr_code = ins; address = adr; opt_code = opc; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (bad) begin
            check("R11 refused start", {29'b0, err, cs_n, done}, {29'b0, 3'b110});
            @(negedge clk);
            check("R11 stays idle", {29'b0, err, cs_n, done}, {29'b0, 3'b010});
            return;
        end
        check("R1 setup cycle", {28'b0, cs_n, sck_en, done, err, io_oe},
                                {28'b0, 4'b0000, 4'b0000});
        li = lanes(mode, 0); la = lanes(mode, 1); ld = lanes(mode, 2);
        ri = (ddr && cmd) ? 2 : 1;
        ra = ddr ? 2 : 1;
        ob = 1 << ol;
        if (ie) chk_phase("R4 instruction", {24'b0, ins}, 8, li, ri, 1, 0, 0, 0, 0);
        if (ae) chk_phase("R5 address", a32 ? adr : {8'b0, adr[23:0]}, a32 ? 32 : 24,
                          la, ra, 1, 0, 0, 0, 0);
        if (oe_) chk_phase("R6 option", {24'b0, opc} & ((32'd1 << ob) - 1), ob, la, ra,
                           1, 0, 0, 0, 0);
        if (dum > 0) chk_phase("R8 dummy", 0, dum, 1, 1, 0, 0, 0, 0, 0);
        if (de) begin
            for (int b = 0; b < nb; b++)
                chk_phase(rd ? "R10 read data" : "R9 write data", {24'b0, txb[b]}, 8, ld, ra,
                          !rd, rd, rxb[b], rd && b > 0, b > 0 ? rxb[b - 1] : 8'h00);
        end
        @(negedge clk);
        io_in_p = 4'b0000;
        io_in_n = 4'b0000;
        check("R1 hold cycle", {28'b0, cs_n, sck_en, done, ddr_act, io_oe},
                               {28'b0, 4'b0010, 4'b0000});
        if (de && rd && nb > 0)
            check("R10 last byte", {23'b0, rx_valid, rx_data}, {23'b0, 1'b1, rxb[nb - 1]});
        if (de && !rd)
            check("R9 pops per byte", pc, nb);
        @(negedge clk);
        check("R1 release", {29'b0, cs_n, done, rx_valid}, {29'b0, 3'b100});
    endtask

    initial begin
        int n = 0;
        repeat (3) @(negedge clk);
        check("R1 reset state", {24'b0, cs_n, sck_en, done, err, io_oe},
                                {24'b0, 4'b1000, 4'b0000});
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", {29'b0, cs_n, sck_en, tx_pop}, {29'b0, 3'b100});
        // Sweep: width mode x rate x instruction rate x address length x option length.
        // Enables, dummy count, byte count and direction rotate with the frame number (R2).
        for (int m = 0; m < 8; m++)
            for (int d = 0; d < 2; d++)
                for (int c = 0; c < 2; c++)
                    for (int a = 0; a < 2; a++)
                        for (int o = 0; o < 4; o++) begin
                            run_frame(m, d[0], c[0], a[0], o, (n % 5) != 1, (n % 3) != 2,
                                      (n % 2) == 0, (n % 4) != 3, n % 4, n % 3,
                                      ((n / 3) % 2) == 1, n);
                            n++;
                        end
        // Long dummy run and multi-byte frames with every phase enabled.
        run_frame(6, 1, 1, 1, 3, 1, 1, 1, 1, 31, 3, 1, 901);
        run_frame(0, 0, 1, 0, 0, 1, 1, 1, 1, 31, 3, 0, 902);
        run_frame(4, 1, 0, 1, 2, 1, 1, 1, 1, 7, 2, 0, 903);
        // Nothing enabled: setup straight to hold (R2).
        run_frame(2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 904);
        if (!ended) begin
            ended = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual expired expected frames finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule